// File: doc/BRIEF.md
# Sequential Constant-Coefficient Multiplier

The block forms `z = C*y + u` for naturals, where `C` is an unsigned constant fixed by a parameter when the design is elaborated, `y` is a `Y_W`-bit operand and `u` is a `C_W`-bit addend. It contains no general multiplier. The multiplicand is consumed in `DIG_W`-bit digits, lowest digit first, one digit per clock, so this is a radix-2^`DIG_W` shift-add machine. Each digit drives a bank of lookup functions whose contents are derived from `C` during elaboration. Each bank entry gives one bit of `C*digit`. A single adder then folds in the upper part that was carried from the previous step.

After each step, the low `DIG_W` bits of the step sum are final result bits and are shifted into the low half of the result. The upper `C_W` bits become the addend for the next digit. The first step uses the external `u` as its addend. When the last digit has been processed, the carried upper part becomes the top of the result. A pulse on `start` captures the operands. `done` then rises after exactly `Y_W/DIG_W` further clocks and stays high, with the result frozen, until the next accepted `start`.

Top module: `cmul_seq_const`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `done` is 0 and `z_out` is 0.
- R2: After a run, `z_out` equals `C_VAL*y + u` for the operands `y_in` and `u_in` that were captured when `start` was accepted. All `C_W+Y_W` bits are the exact natural result.
- R3: When `start` is accepted at a clock edge, `done` is low after that edge. It rises at exactly the `Y_W/DIG_W`-th following edge.
- R4: Once `done` is high, `done` and `z_out` keep their values until the next accepted `start`.
- R5: A `start` that arrives while a run is in progress is ignored. The run finishes at its original time with its original operands.
- R6: A `start` accepted while `done` is high clears `done` at that edge and begins a new run on the new operands.
- R7: With the largest values of `y` and `u`, the result reaches `C_VAL*(2^Y_W-1) + 2^C_W-1` exactly. No step sum overflows its `C_W+DIG_W` bits.
- R8: Changes on `y_in` and `u_in` after `start` has been accepted have no effect on the result of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when no run is in progress |
| y_in | input | Y_W | Natural multiplicand, consumed digit by digit |
| u_in | input | C_W | Natural addend |
| z_out | output | C_W+Y_W | Registered result |
| done | output | 1 | Result valid; held until the next accepted start |

## Verification
The bench builds the block with an 8-bit constant of 173, 6-bit digits and an 18-bit multiplicand. Every run therefore takes three digit steps, and the feedback path is exercised twice within a run. These values allow exact expected results in 64-bit arithmetic, including the all-ones operands that push every step sum close to its limit. A digit count of three also leaves a middle cycle in which a stray start or an operand change can land while a run is in progress.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  localparam int MAX_DIG_W = 8;
  localparam int MAX_TBL   = 1 << MAX_DIG_W;

  typedef logic [MAX_TBL-1:0] fn_bits_t;

  // Truth table of bit 'pos' of cval*d for every digit value d.
  function automatic fn_bits_t bit_function(input longint unsigned cval,
                                            input int dig_w, input int pos);
    fn_bits_t f;
    longint unsigned prod;
    f = '0;
    for (int d = 0; d < (1 << dig_w); d++) begin
      prod = cval * longint'(d);
      f[d] = prod[pos];
    end
    return f;
  endfunction
endpackage

// File: rtl/cmul_digit_table.sv
module cmul_digit_table #(
  parameter int          C_W   = 8,
  parameter int          DIG_W = 6,
  parameter logic [C_W-1:0] C_VAL = 173
) (
  input  logic [DIG_W-1:0]     digit,
  output logic [C_W+DIG_W-1:0] prod
);
  import cmul_pkg::*;
  localparam int P_W = C_W + DIG_W;
  localparam int TBL = 1 << DIG_W;

  for (genvar j = 0; j < P_W; j++) begin : g_bit
    localparam fn_bits_t FN_FULL = bit_function(longint'(C_VAL), DIG_W, j);
    localparam logic [TBL-1:0] FN = FN_FULL[TBL-1:0];
    assign prod[j] = FN[digit];
  end
endmodule

// File: rtl/cmul_step.sv
module cmul_step #(
  parameter int          C_W   = 8,
  parameter int          DIG_W = 6,
  parameter logic [C_W-1:0] C_VAL = 173
) (
  input  logic [DIG_W-1:0] digit,
  input  logic [C_W-1:0]   addend,
  output logic [DIG_W-1:0] lo,
  output logic [C_W-1:0]   hi
);
  localparam int P_W = C_W + DIG_W;

  logic [P_W-1:0] prod;
  logic [P_W:0]   sum;

  cmul_digit_table #(.C_W(C_W), .DIG_W(DIG_W), .C_VAL(C_VAL)) u_table (
    .digit(digit),
    .prod (prod)
  );

  always_comb begin
    sum = {1'b0, prod} + {{(DIG_W+1){1'b0}}, addend};
    if (!$isunknown(sum)) begin
      p_no_overflow_r7: assert (sum[P_W] == 1'b0)
        else $error("step sum exceeds its width");
    end
  end

  assign lo = sum[DIG_W-1:0];
  assign hi = sum[P_W-1:DIG_W];
endmodule

// File: rtl/cmul_ctrl.sv
module cmul_ctrl #(
  parameter int N_DIG = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic busy,
  output logic last,
  output logic done
);
  localparam int CNT_W = (N_DIG > 1) ? $clog2(N_DIG) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(N_DIG - 1);

  logic [CNT_W-1:0] cnt;

  assign load = start && !busy;
  assign last = busy && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= '0;
      done <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> !done);
  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));
  p_stray_start_r5: assert property (@(posedge clk) disable iff (rst)
    busy && !last |=> busy && $stable(done));
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    done && start |=> !done && busy);
endmodule

// File: rtl/cmul_seq_const.sv
module cmul_seq_const #(
  parameter int          C_W   = 8,
  parameter int          DIG_W = 6,
  parameter int          Y_W   = 18,
  parameter logic [C_W-1:0] C_VAL = 173
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [Y_W-1:0]     y_in,
  input  logic [C_W-1:0]     u_in,
  output logic [C_W+Y_W-1:0] z_out,
  output logic               done
);
  localparam int N_DIG = Y_W / DIG_W;

  initial begin
    if (Y_W % DIG_W != 0) $error("Y_W must be a multiple of DIG_W");
    if (DIG_W > cmul_pkg::MAX_DIG_W) $error("DIG_W too large");
  end

  logic             load, busy, last;
  logic [Y_W-1:0]   y_sh;
  logic [Y_W-1:0]   low_sh;
  logic [Y_W-1:0]   next_low;
  logic [C_W-1:0]   carry_q;
  logic [DIG_W-1:0] step_lo;
  logic [C_W-1:0]   step_hi;

  cmul_ctrl #(.N_DIG(N_DIG)) u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .load (load),
    .busy (busy),
    .last (last),
    .done (done)
  );

  cmul_step #(.C_W(C_W), .DIG_W(DIG_W), .C_VAL(C_VAL)) u_step (
    .digit (y_sh[DIG_W-1:0]),
    .addend(carry_q),
    .lo    (step_lo),
    .hi    (step_hi)
  );

  if (N_DIG > 1) begin : g_multi
    assign next_low = {step_lo, low_sh[Y_W-1:DIG_W]};
  end else begin : g_single
    assign next_low = step_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_sh    <= '0;
      low_sh  <= '0;
      carry_q <= '0;
      z_out   <= '0;
    end else if (load) begin
      y_sh    <= y_in;
      carry_q <= u_in;
      low_sh  <= '0;
    end else if (busy) begin
      y_sh    <= y_sh >> DIG_W;
      carry_q <= step_hi;
      low_sh  <= next_low;
      if (last) z_out <= {step_hi, next_low};
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> z_out == '0);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done && $stable(z_out));
  p_frozen_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy && !last |=> $stable(z_out));
endmodule

// File: tb/cmul_seq_const_bench.sv
module cmul_seq_const_bench;
  localparam int CLK_PERIOD = 10;
  localparam int C_W   = 8;
  localparam int DIG_W = 6;
  localparam int Y_W   = 18;
  localparam int N_DIG = Y_W / DIG_W;
  localparam int Z_W   = C_W + Y_W;
  localparam logic [C_W-1:0] C_VAL = 8'd173;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [Y_W-1:0] y_in = '0;
  logic [C_W-1:0] u_in = '0;
  logic [Z_W-1:0] z_out;
  logic           done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmul_seq_const #(.C_W(C_W), .DIG_W(DIG_W), .Y_W(Y_W), .C_VAL(C_VAL)) u_cmul_seq_const (
    .clk(clk), .rst(rst), .start(start), .y_in(y_in), .u_in(u_in),
    .z_out(z_out), .done(done)
  );

  function automatic logic [Z_W-1:0] expect_z(input logic [Y_W-1:0] y, input logic [C_W-1:0] u);
    longint unsigned r;
    r = longint'(C_VAL) * longint'(y) + longint'(u);
    return r[Z_W-1:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Start at a negedge; returns at the negedge after the completing edge,
  // checking done timing on every intermediate negedge (R3).
  task automatic run(input logic [Y_W-1:0] y, input logic [C_W-1:0] u, input string req);
    @(negedge clk);
    start = 1'b1; y_in = y; u_in = u;
    @(negedge clk);
    start = 1'b0;
    check("R3 done low after start", 64'(done), 64'd0);
    for (int i = 1; i <= N_DIG; i++) begin
      @(negedge clk);
      check("R3 done timing", 64'(done), 64'(i == N_DIG));
    end
    check(req, 64'(z_out), 64'(expect_z(y, u)));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 done at reset", 64'(done), 64'd0);
    check("R1 result at reset", 64'(z_out), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", 64'(done), 64'd0);
  endtask

  task automatic t_patterns();
    run(18'd1, 8'd0, "R2 y=1");
    run(18'd0, 8'd0, "R2 zero");
    run(18'h2A5C3, 8'd77, "R2 mixed");
    run(18'h00040, 8'd255, "R2 second digit");
    run(18'h3F000, 8'd1, "R2 top digit");
  endtask

  task automatic t_extremes();
    run(18'h3FFFF, 8'hFF, "R7 max operands");
    check("R7 exact max", 64'(z_out),
          64'(longint'(C_VAL) * ((longint'(1) << Y_W) - 1) + 255));
  endtask

  task automatic t_hold();
    logic [Z_W-1:0] snap;
    run(18'h12345, 8'd9, "R2 before hold");
    snap = z_out;
    repeat (5) @(negedge clk);
    check("R4 done held", 64'(done), 64'd1);
    check("R4 result held", 64'(z_out), 64'(snap));
  endtask

  task automatic t_busy_start();
    @(negedge clk);
    start = 1'b1; y_in = 18'h0ABCD; u_in = 8'd33;
    @(negedge clk);
    y_in = 18'h3FFFF; u_in = 8'd200;  // stray start while busy
    @(negedge clk);
    start = 1'b0;
    check("R5 not done early", 64'(done), 64'd0);
    repeat (N_DIG - 1) @(negedge clk);
    check("R5 done on time", 64'(done), 64'd1);
    check("R5 original operands", 64'(z_out), 64'(expect_z(18'h0ABCD, 8'd33)));
    repeat (2) @(negedge clk);
    check("R5 no second run", 64'(z_out), 64'(expect_z(18'h0ABCD, 8'd33)));
  endtask

  task automatic t_input_change();
    @(negedge clk);
    start = 1'b1; y_in = 18'h1F0F0; u_in = 8'd5;
    @(negedge clk);
    start = 1'b0; y_in = 18'h00001; u_in = 8'd250;
    repeat (N_DIG) @(negedge clk);
    check("R8 inputs ignored", 64'(z_out), 64'(expect_z(18'h1F0F0, 8'd5)));
  endtask

  task automatic t_restart();
    check("R6 done before restart", 64'(done), 64'd1);
    @(negedge clk);
    start = 1'b1; y_in = 18'h2222A; u_in = 8'd100;
    @(negedge clk);
    start = 1'b0;
    check("R6 done cleared", 64'(done), 64'd0);
    repeat (N_DIG) @(negedge clk);
    check("R6 new result", 64'(z_out), 64'(expect_z(18'h2222A, 8'd100)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_patterns();
    t_extremes();
    t_hold();
    t_busy_start();
    t_input_change();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule